// File: doc/BRIEF.md
# Supervised System Reset Generator with Watchdog

This block produces an active-low system reset for a board or subsystem. It holds reset asserted until a power-good input has stayed true for a programmable number of cycles. It then releases reset and supervises the software through a watchdog kick input. Every delay comes from a configuration input and is counted in clock cycles. Each value is captured when the phase that uses it begins.

After each release there is a grace window in which kicks are neither needed nor counted. Once that window ends, each rising edge on the kick input restarts the watchdog period. If a period passes with no kick, the block asserts reset for a programmable time and releases it again. A fresh grace window then starts. A one-cycle configuration-update strobe forces reset low for a fixed hold time, even when power is good. After the hold, the power-good conditions are checked again from the start. A status bit records whether the most recent reset came from a watchdog expiry.

Top module: `rst_watchdog_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sys_rst_n` is 0 and `wd_cause` is 0.
- R2: `pgood_in` passes through a two-stage synchronizer. If it rises before clock edge 1 and stays high, `sys_rst_n` goes to 1 at edge 3+max(D,1), where D = `cfg_release_dly`.
- R3: If `pgood_in` falls before edge 1, `sys_rst_n` is 0 from edge 3. Any release countdown in progress is abandoned, and the full release delay restarts when power-good returns.
- R4: After each release, kicks are ignored for max(S,1) cycles (S = `cfg_start_time`). With no effective kick, reset stays released for exactly max(S,1)+max(P,1) cycles (P = `cfg_wd_period`).
- R5: A kick is a 0-to-1 change of the synchronized `wdi_in`. A rise before edge 1, made after the grace window, reloads the period at edge 3. Reset then falls at edge 3+max(P,1) unless another kick arrives.
- R6: A watchdog expiry holds `sys_rst_n` at 0 for max(R,1) cycles (R = `cfg_reset_time`). Reset is then released and a new grace window of max(S,1) cycles begins.
- R7: A `cfg_update` pulse sampled while synchronized power-good is 1 drives `sys_rst_n` to 0 at that edge and holds it for 16 cycles. The block then waits for power-good and the release delay again, so release comes at edge 18+max(D,1).
- R8: `wd_cause` goes to 1 when a watchdog expiry asserts reset. It returns to 0 whenever synchronized power-good is 0. A `cfg_update` leaves it unchanged.
- R9: A change to a delay input while its phase is running does not alter that phase; the value is taken when the phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pgood_in | input | 1 | Asynchronous power-good level |
| wdi_in | input | 1 | Asynchronous watchdog kick input |
| cfg_update | input | 1 | One-cycle strobe marking a configuration change |
| cfg_release_dly | input | CNT_W | Cycles of good power before reset release |
| cfg_start_time | input | CNT_W | Grace window after each release |
| cfg_wd_period | input | CNT_W | Watchdog timeout in cycles |
| cfg_reset_time | input | CNT_W | Reset width after a watchdog expiry |
| sys_rst_n | output | 1 | Active-low system reset, registered |
| wd_cause | output | 1 | 1 when the latest reset came from a watchdog expiry |

## Verification
The bench sweeps every delay through zero, one and small values. A design that counts zero as a full counter wrap, or that is off by one, shows up as a wrong release edge or a wrong reset width. It places kicks inside the grace window to catch a design that counts kicks too early, and it spaces kicks just inside the period to catch one that reloads late. It also drops power-good during a release countdown and during a watchdog reset, and strobes reconfiguration with `wd_cause` set. These catch a design that resumes a stale countdown, skips the forced hold, or clears or keeps the cause bit at the wrong time. Finally, it changes a delay input in the middle of a phase, which exposes a design that reads its configuration live.

// File: rtl/rstwd_pkg.sv
package rstwd_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PG = 3'd0,
    ST_REL     = 3'd1,
    ST_START   = 3'd2,
    ST_WATCH   = 3'd3,
    ST_WDRST   = 3'd4,
    ST_CFG     = 3'd5
  } rstwd_state_e;

endpackage

// File: rtl/rstwd_sync.sv
module rstwd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rstwd_timer.sv
module rstwd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  // Phase ends when one cycle or less remains, so 0 and 1 both give one cycle.
  assign done = (cnt[CNT_W-1:1] == '0);

  a_r9_load_captures: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  a_r6_idle_holds_zero: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/rst_watchdog_gen.sv
module rst_watchdog_gen
  import rstwd_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int CFG_HOLD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pgood_in,
  input  logic             wdi_in,
  input  logic             cfg_update,
  input  logic [CNT_W-1:0] cfg_release_dly,
  input  logic [CNT_W-1:0] cfg_start_time,
  input  logic [CNT_W-1:0] cfg_wd_period,
  input  logic [CNT_W-1:0] cfg_reset_time,
  output logic             sys_rst_n,
  output logic             wd_cause
);

  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(CFG_HOLD_CYC);

  logic         pg_s, wdi_s, wdi_q, kick;
  logic         tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  rstwd_state_e state, nstate;
  logic         cause_n;

  rstwd_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk(clk), .rst(rst), .din(pgood_in), .dout(pg_s)
  );

  rstwd_sync #(.STAGES(SYNC_STAGES)) u_wdi_sync (
    .clk(clk), .rst(rst), .din(wdi_in), .dout(wdi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) wdi_q <= 1'b0;
    else     wdi_q <= wdi_s;
  end

  assign kick = wdi_s & ~wdi_q;

  rstwd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  // Sequencer: power loss wins over reconfiguration, which wins over phases.
  always_comb begin
    nstate   = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cause_n  = wd_cause;
    if (!pg_s) begin
      nstate  = ST_WAIT_PG;
      cause_n = 1'b0;
    end else if (cfg_update) begin
      nstate   = ST_CFG;
      tmr_load = 1'b1;
      tmr_val  = HOLD_VAL;
    end else begin
      case (state)
        ST_WAIT_PG: begin
          nstate   = ST_REL;
          tmr_load = 1'b1;
          tmr_val  = cfg_release_dly;
        end
        ST_REL: if (tmr_done) begin
          nstate   = ST_START;
          tmr_load = 1'b1;
          tmr_val  = cfg_start_time;
        end
        ST_START: if (tmr_done) begin
          nstate   = ST_WATCH;
          tmr_load = 1'b1;
          tmr_val  = cfg_wd_period;
        end
        ST_WATCH: begin
          if (kick) begin
            tmr_load = 1'b1;
            tmr_val  = cfg_wd_period;
          end else if (tmr_done) begin
            nstate   = ST_WDRST;
            tmr_load = 1'b1;
            tmr_val  = cfg_reset_time;
            cause_n  = 1'b1;
          end
        end
        ST_WDRST: if (tmr_done) begin
          nstate   = ST_START;
          tmr_load = 1'b1;
          tmr_val  = cfg_start_time;
        end
        ST_CFG: if (tmr_done) nstate = ST_WAIT_PG;
        default: nstate = ST_WAIT_PG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_PG;
      sys_rst_n <= 1'b0;
      wd_cause  <= 1'b0;
    end else begin
      state     <= nstate;
      sys_rst_n <= (nstate == ST_START) || (nstate == ST_WATCH);
      wd_cause  <= cause_n;
    end
  end

  a_r3_pg_loss_asserts: assert property (@(posedge clk) disable iff (rst)
    !pg_s |=> !sys_rst_n);

  a_r7_cfg_forces_reset: assert property (@(posedge clk) disable iff (rst)
    (pg_s && cfg_update) |=> !sys_rst_n);

  a_r8_cause_with_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_cause) |-> $fell(sys_rst_n));

  a_r2_release_needs_pg: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(pg_s));

  a_r5_kick_keeps_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH && kick && pg_s && !cfg_update) |=> sys_rst_n);

endmodule

// File: tb/sim_rst_watchdog_gen.sv
module sim_rst_watchdog_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, pgood_in, wdi_in, cfg_update;
  logic [W-1:0] rdly, stime, wper, rtime;
  logic sys_rst_n, wd_cause;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_watchdog_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .pgood_in(pgood_in), .wdi_in(wdi_in),
    .cfg_update(cfg_update), .cfg_release_dly(rdly), .cfg_start_time(stime),
    .cfg_wd_period(wper), .cfg_reset_time(rtime),
    .sys_rst_n(sys_rst_n), .wd_cause(wd_cause)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic count_until(input logic lvl, input int lim, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (sys_rst_n !== lvl && n < lim);
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic hw_reset();
    rst = 1'b1; pgood_in = 1'b0; wdi_in = 1'b0; cfg_update = 1'b0;
    repeat (3) tick();
    chk(sys_rst_n == 1'b0, "R1 reset held during rst", sys_rst_n, 0);
    rst = 1'b0;
    tick();
    chk(sys_rst_n == 1'b0 && wd_cause == 1'b0, "R1 state after rst",
        {sys_rst_n, wd_cause}, 0);
  endtask

  task automatic set_cfg(input int d, input int s, input int p, input int r);
    rdly = W'(d); stime = W'(s); wper = W'(p); rtime = W'(r);
  endtask

  initial begin
    int n, m, m2, m3;
    bit held;
    int dl[5] = '{0, 1, 2, 7, 12};
    int sl[3] = '{0, 1, 3};
    int pl[3] = '{1, 2, 5};
    int rl[3] = '{0, 2, 4};
    set_cfg(1, 50, 50, 1);
    hw_reset();

    // R2: release delay sweep
    foreach (dl[i]) begin
      hw_reset();
      set_cfg(dl[i], 100, 100, 1);
      pgood_in = 1'b1;
      count_until(1'b1, 200, n);
      chk(n == 3 + mx1(dl[i]), "R2 release edge", n, 3 + mx1(dl[i]));
    end

    // R3: power loss while released, then abort of a running release delay
    pgood_in = 1'b0;
    count_until(1'b0, 50, n);
    chk(n == 3, "R3 assert after pg loss", n, 3);
    chk(wd_cause == 1'b0, "R8 cause after pg loss", wd_cause, 0);
    pgood_in = 1'b1;
    repeat (5) tick();
    pgood_in = 1'b0;
    repeat (2) tick();
    chk(sys_rst_n == 1'b0, "R3 still held during glitch", sys_rst_n, 0);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    chk(n == 3 + 12, "R3 delay restarts after glitch", n, 15);

    // R4 / R6 / R8: grace, period and reset-width sweep without kicks
    foreach (sl[a]) foreach (pl[b]) foreach (rl[c]) begin
      hw_reset();
      set_cfg(1, sl[a], pl[b], rl[c]);
      pgood_in = 1'b1;
      count_until(1'b1, 200, n);
      count_until(1'b0, 400, m);
      chk(m == mx1(sl[a]) + mx1(pl[b]), "R4 released span", m, mx1(sl[a]) + mx1(pl[b]));
      chk(wd_cause == 1'b1, "R8 cause after expiry", wd_cause, 1);
      count_until(1'b1, 400, m2);
      chk(m2 == mx1(rl[c]), "R6 reset width", m2, mx1(rl[c]));
      count_until(1'b0, 400, m3);
      chk(m3 == mx1(sl[a]) + mx1(pl[b]), "R6 new grace window", m3, mx1(sl[a]) + mx1(pl[b]));
    end

    // R4: kicks inside the grace window are ignored
    hw_reset();
    set_cfg(1, 8, 3, 2);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    wdi_in = 1'b1; repeat (2) tick();
    wdi_in = 1'b0; repeat (2) tick();
    wdi_in = 1'b1;
    count_until(1'b0, 200, m);
    chk(4 + m == 11, "R4 grace kicks ignored", 4 + m, 11);
    wdi_in = 1'b0;

    // R5: regular kicks sustain release; timeout measured from last kick
    hw_reset();
    set_cfg(1, 2, 6, 2);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    held = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wdi_in = 1'b1;
      repeat (2) begin tick(); if (!sys_rst_n) held = 1'b0; end
      wdi_in = 1'b0;
      repeat (2) begin tick(); if (!sys_rst_n) held = 1'b0; end
    end
    chk(held, "R5 kicks keep reset released", held, 1);
    wdi_in = 1'b1;
    repeat (2) tick();
    wdi_in = 1'b0;
    count_until(1'b0, 200, m);
    chk(2 + m == 9, "R5 timeout after last kick", 2 + m, 9);

    // R7: reconfiguration with good power, cause clear
    hw_reset();
    set_cfg(4, 100, 100, 1);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    cfg_update = 1'b1; tick(); cfg_update = 1'b0;
    chk(sys_rst_n == 1'b0, "R7 immediate assertion", sys_rst_n, 0);
    count_until(1'b1, 200, m);
    chk(1 + m == 22, "R7 hold then release delay", 1 + m, 22);
    chk(wd_cause == 1'b0, "R8 cause kept clear by cfg", wd_cause, 0);

    // R7 / R8: reconfiguration after a watchdog expiry keeps the cause
    hw_reset();
    set_cfg(1, 1, 2, 3);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    count_until(1'b0, 200, n);
    count_until(1'b1, 200, n);
    set_cfg(5, 100, 100, 1);
    cfg_update = 1'b1; tick(); cfg_update = 1'b0;
    count_until(1'b1, 200, m);
    chk(1 + m == 23, "R7 release after cfg with new delay", 1 + m, 23);
    chk(wd_cause == 1'b1, "R8 cause kept by cfg", wd_cause, 1);

    // R8: power loss during a watchdog reset clears the cause
    hw_reset();
    set_cfg(1, 1, 1, 40);
    pgood_in = 1'b1;
    count_until(1'b1, 200, n);
    count_until(1'b0, 200, n);
    chk(wd_cause == 1'b1, "R8 cause set", wd_cause, 1);
    pgood_in = 1'b0;
    repeat (4) tick();
    chk(wd_cause == 1'b0, "R8 cause cleared by pg loss", wd_cause, 0);
    chk(sys_rst_n == 1'b0, "R3 reset held after pg loss", sys_rst_n, 0);

    // R9: delay value changed mid-phase has no effect
    hw_reset();
    set_cfg(10, 100, 100, 1);
    pgood_in = 1'b1;
    repeat (5) tick();
    rdly = W'(2);
    count_until(1'b1, 200, m);
    chk(5 + m == 13, "R9 captured release delay", 5 + m, 13);

    // R1: block reset while released
    rst = 1'b1;
    tick();
    chk(sys_rst_n == 1'b0, "R1 rst forces reset", sys_rst_n, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule